// File: doc/BRIEF.md
# Key-Side Challenge Stream Checker

This block plays the key's half of a lockstep challenge-response exchange with a lock. Two exchange partners share the link: the key sends one bit on a serial output and the lock sends one bit back on a serial input. The block holds two nibble seed banks: an own bank and a lock bank. Each round walks a seed index from a start value up to the last nibble. For every index the block derives a bit to send from the own bank and a bit to expect from the lock bank. It drives its bit, waits, samples the lock's reply and compares the reply with the prediction. A single disagreement parks the block in a terminal halt.

When a round completes cleanly, the block emits a one-cycle host reset pulse. It then asks an external scrambling unit for three consecutive passes over both banks. Each pass is answered with a bank write that replaces the contents of both banks. After the third pass the block exchanges two lock-bank nibbles. From that bank it takes the next round's mode bit and start index, then starts the next round at once. Seeds are loaded through the same write strobe while the block is idle, and the first round begins on an init-done strobe.

Top module: `key_stream_checker`

## Requirements
- R1: After reset, key_tx, host_rst, scr_req and halted are 0, mode_bit is 1 and round_cnt is 0.
- R2: While idle and before init_done, bank_wr loads own_wdata and lock_wdata into the banks (seen on own_bank and lock_bank; nibble i occupies bits 4i+3..4i), and key_tx stays 0.
- R3: Each index takes a 3-cycle slot. key_tx is held for the last two cycles of the slot at the LSB of the own nibble at that index when mode_bit is 1, and at 0 when mode_bit is 0. key_tx is 0 in the first cycle of the slot.
- R4: lock_rx is sampled in the last cycle of the slot and compared with the prediction. The prediction is bit 0 of the lock work value in mode 1 and bit 1 of it in mode 0. The work value is 7 for an odd nibble and 0 otherwise, masked with 1101b in mode 1 or 1010b in mode 0. In effect, the prediction is the lock nibble's LSB.
- R5: A mismatch sets halted, which stays 1 until reset. While halted, key_tx and scr_req stay 0, the index stays at the failing slot and round_cnt is frozen.
- R6: The first round starts at index 1, and every round ends after index 15 (cur_index shows the slot index).
- R7: After index 15 passes, host_rst is high for exactly one cycle. Then scr_req is raised three times, and each request is ended by one bank_wr that reloads both banks.
- R8: After the third scrambler write, lock nibbles 3 and 7 are exchanged and the own bank is left as written.
- R9: mode_bit is loaded from the LSB of lock nibble 3 after the exchange, and it changes at no other time except reset.
- R10: The next round starts at index 1 if lock nibble 3 was odd before the exchange, and otherwise at that nibble's value.
- R11: round_cnt increases by exactly one when a round's exchange completes.
- R12: bank_wr during a round's bit slots has no effect on either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Starts the first round when idle |
| bank_wr | input | 1 | Bank write strobe: seed load when idle, scrambler answer otherwise |
| own_wdata | input | 64 | New own-bank contents |
| lock_wdata | input | 64 | New lock-bank contents |
| lock_rx | input | 1 | Bit received from the lock |
| key_tx | output | 1 | Bit sent to the lock |
| host_rst | output | 1 | One-cycle pulse at the end of a round |
| scr_req | output | 1 | Scramble pass request |
| own_bank | output | 64 | Own bank contents |
| lock_bank | output | 64 | Lock bank contents |
| cur_index | output | 4 | Current seed index |
| mode_bit | output | 1 | Current derivation mode |
| round_cnt | output | 8 | Completed rounds |
| halted | output | 1 | Terminal mismatch flag |

## Verification
A mode-1 round from index 1 with mixed own-nibble parities tells a correct send bit apart from an inverted or index-shifted one. The same round also checks the exact number of key_tx high cycles. A mode-0 round then shows that the key stays silent while replies are still checked against the lock nibble's LSB. Without that round, a wrong mask or a wrong bit selection in the comparison would go unseen. Scrambler answers are chosen so that an odd nibble 3 restarts at index 1, an even one restarts at index 6, and the mode flips both ways. A stray write mid-round, and a deliberately wrong reply at index 9, separate the ignored-write case and the sticky halt from their broken variants.

// File: rtl/ksc_pkg.sv
package ksc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREP,
    ST_DRIVE,
    ST_SAMP,
    ST_PULSE,
    ST_SCR,
    ST_GAP,
    ST_SWAP,
    ST_HALT
  } ksc_state_t;

  // Work value of a nibble under the current mode.
  function automatic logic [3:0] work_value(input logic nib_lsb, input logic mode);
    logic [3:0] raw;
    raw = nib_lsb ? 4'd7 : 4'd0;
    return mode ? (raw & 4'b1101) : (raw & 4'b1010);
  endfunction

endpackage

// File: rtl/ksc_seed_bank.sv
module ksc_seed_bank #(
  parameter int NIB_W  = 4,
  parameter int NIB_N  = 16,
  parameter int SWAP_A = 3,
  parameter int SWAP_B = 7,
  localparam int IDX_W  = $clog2(NIB_N),
  localparam int BANK_W = NIB_W * NIB_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BANK_W-1:0] load_data,
  input  logic              swap,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BANK_W-1:0] bank_flat,
  output logic [NIB_W-1:0]  rd_nib
);

  logic [NIB_W-1:0] mem [NIB_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NIB_N; i++) mem[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NIB_N; i++) mem[i] <= load_data[i*NIB_W +: NIB_W];
    end else if (swap) begin
      mem[SWAP_A] <= mem[SWAP_B];
      mem[SWAP_B] <= mem[SWAP_A];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NIB_N; g++) begin : g_flat
      assign bank_flat[g*NIB_W +: NIB_W] = mem[g];
    end
  endgenerate

  assign rd_nib = mem[rd_idx];

endmodule

// File: rtl/ksc_bit_derive.sv
module ksc_bit_derive #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] own_nib,
  input  logic [NIB_W-1:0] lock_nib,
  input  logic             mode,
  output logic             send_bit,
  output logic             expect_bit
);
  import ksc_pkg::*;

  logic [3:0] own_w;
  logic [3:0] lock_w;

  always_comb begin
    own_w      = work_value(own_nib[0], mode);
    lock_w     = work_value(lock_nib[0], mode);
    send_bit   = own_w[0];
    expect_bit = mode ? lock_w[0] : lock_w[1];
  end

endmodule

// File: rtl/key_stream_checker.sv
module key_stream_checker #(
  parameter int NIB_W     = 4,
  parameter int NIB_N     = 16,
  parameter int PASSES    = 3,
  parameter int SWAP_A    = 3,
  parameter int SWAP_B    = 7,
  parameter int FIRST_IDX = 1,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(NIB_N),
  localparam int BANK_W   = NIB_W * NIB_N,
  localparam int PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] own_wdata,
  input  logic [BANK_W-1:0] lock_wdata,
  input  logic              lock_rx,
  output logic              key_tx,
  output logic              host_rst,
  output logic              scr_req,
  output logic [BANK_W-1:0] own_bank,
  output logic [BANK_W-1:0] lock_bank,
  output logic [IDX_W-1:0]  cur_index,
  output logic              mode_bit,
  output logic [CNT_W-1:0]  round_cnt,
  output logic              halted
);
  import ksc_pkg::*;

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NIB_N - 1);
  localparam logic [IDX_W-1:0]  START_IDX = IDX_W'(FIRST_IDX);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

  ksc_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [PASS_W-1:0] pass;
  logic              mode;
  logic              exp_q;

  logic              bank_load;
  logic              swap_go;
  logic [NIB_W-1:0]  own_nib;
  logic [NIB_W-1:0]  lock_nib;
  logic              send_c;
  logic              expect_c;
  logic [NIB_W-1:0]  nib_a;
  logic [NIB_W-1:0]  nib_b;
  logic [IDX_W-1:0]  next_start;

  assign bank_load = bank_wr && (state == ST_IDLE || state == ST_SCR);
  assign swap_go   = (state == ST_SWAP);

  ksc_seed_bank #(.NIB_W(NIB_W), .NIB_N(NIB_N), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)) u_own (
    .clk(clk), .rst(rst), .load(bank_load), .load_data(own_wdata),
    .swap(1'b0), .rd_idx(idx), .bank_flat(own_bank), .rd_nib(own_nib)
  );

  ksc_seed_bank #(.NIB_W(NIB_W), .NIB_N(NIB_N), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)) u_lock (
    .clk(clk), .rst(rst), .load(bank_load), .load_data(lock_wdata),
    .swap(swap_go), .rd_idx(idx), .bank_flat(lock_bank), .rd_nib(lock_nib)
  );

  ksc_bit_derive #(.NIB_W(NIB_W)) u_derive (
    .own_nib(own_nib), .lock_nib(lock_nib), .mode(mode),
    .send_bit(send_c), .expect_bit(expect_c)
  );

  // Pre-exchange nibbles: A decides the start index, B becomes the new A.
  always_comb begin
    nib_a      = lock_bank[SWAP_A*NIB_W +: NIB_W];
    nib_b      = lock_bank[SWAP_B*NIB_W +: NIB_W];
    next_start = nib_a[0] ? START_IDX : IDX_W'(nib_a);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= START_IDX;
      pass      <= '0;
      mode      <= 1'b1;
      exp_q     <= 1'b0;
      key_tx    <= 1'b0;
      host_rst  <= 1'b0;
      scr_req   <= 1'b0;
      round_cnt <= '0;
      halted    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (init_done) begin
            idx   <= START_IDX;
            state <= ST_PREP;
          end
        end
        ST_PREP: begin
          exp_q  <= expect_c;
          key_tx <= send_c;
          state  <= ST_DRIVE;
        end
        ST_DRIVE: state <= ST_SAMP;
        ST_SAMP: begin
          key_tx <= 1'b0;
          if (lock_rx != exp_q) begin
            halted <= 1'b1;
            state  <= ST_HALT;
          end else if (idx == LAST_IDX) begin
            host_rst <= 1'b1;
            state    <= ST_PULSE;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_PREP;
          end
        end
        ST_PULSE: begin
          host_rst <= 1'b0;
          scr_req  <= 1'b1;
          pass     <= '0;
          state    <= ST_SCR;
        end
        ST_SCR: begin
          if (bank_wr) begin
            scr_req <= 1'b0;
            if (pass == LAST_PASS) begin
              state <= ST_SWAP;
            end else begin
              pass  <= pass + 1'b1;
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          scr_req <= 1'b1;
          state   <= ST_SCR;
        end
        ST_SWAP: begin
          mode      <= nib_b[0];
          idx       <= next_start;
          round_cnt <= round_cnt + 1'b1;
          state     <= ST_PREP;
        end
        default: begin
          key_tx  <= 1'b0;
          scr_req <= 1'b0;
        end
      endcase
    end
  end

  assign cur_index = idx;
  assign mode_bit  = mode;

endmodule

// File: rtl/ksc_checker.sv
module ksc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             halted,
  input logic             key_tx,
  input logic             scr_req,
  input logic             host_rst,
  input logic             bank_wr,
  input logic             mode_bit,
  input logic [CNT_W-1:0] round_cnt
);

  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!key_tx && !scr_req));

  p_host_rst_single_r7: assert property (@(posedge clk) disable iff (rst)
    host_rst |=> !host_rst);

  p_req_ends_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    (scr_req && bank_wr) |=> !scr_req);

  p_round_step_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(round_cnt) |-> (round_cnt == CNT_W'($past(round_cnt) + 1'b1)));

  p_mode_at_round_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_bit) |-> !$stable(round_cnt));

endmodule

bind key_stream_checker ksc_checker #(.CNT_W(CNT_W)) u_ksc_checker (
  .clk(clk), .rst(rst), .halted(halted), .key_tx(key_tx), .scr_req(scr_req),
  .host_rst(host_rst), .bank_wr(bank_wr), .mode_bit(mode_bit), .round_cnt(round_cnt)
);

// File: tb/key_stream_checker_test.sv
module key_stream_checker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_done = 1'b0;
  logic        bank_wr = 1'b0;
  logic [63:0] own_wdata = '0;
  logic [63:0] lock_wdata = '0;
  logic        lock_rx = 1'b0;
  logic        key_tx, host_rst, scr_req, mode_bit, halted;
  logic [63:0] own_bank, lock_bank;
  logic [3:0]  cur_index;
  logic [7:0]  round_cnt;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [63:0] m_own  = '0;
  logic [63:0] m_lock = '0;
  bit          corrupt = 1'b0;
  int          bad_idx = 0;

  key_stream_checker uut (
    .clk(clk), .rst(rst), .init_done(init_done), .bank_wr(bank_wr),
    .own_wdata(own_wdata), .lock_wdata(lock_wdata), .lock_rx(lock_rx),
    .key_tx(key_tx), .host_rst(host_rst), .scr_req(scr_req),
    .own_bank(own_bank), .lock_bank(lock_bank), .cur_index(cur_index),
    .mode_bit(mode_bit), .round_cnt(round_cnt), .halted(halted)
  );

  always #2 clk = ~clk;

  // Lock model: reply with the LSB of the lock nibble at the shown index.
  always @(negedge clk) begin
    lock_rx = m_lock[cur_index*4] ^ (corrupt && (int'(cur_index) == bad_idx));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] swp(input logic [63:0] x);
    logic [63:0] t;
    t = x;
    t[15:12] = x[31:28];
    t[31:28] = x[15:12];
    return t;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    corrupt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(key_tx == 0 && host_rst == 0 && scr_req == 0, "R1 outputs idle", {key_tx, host_rst, scr_req}, 0);
    chk(halted == 0, "R1 halted", halted, 0);
    chk(mode_bit == 1, "R1 mode", mode_bit, 1);
    chk(round_cnt == 0, "R1 round_cnt", round_cnt, 0);
  endtask

  task automatic t_idle_load(input logic [63:0] o, input logic [63:0] l);
    int hi = 0;
    own_wdata = o; lock_wdata = l; bank_wr = 1'b1;
    @(negedge clk);
    bank_wr = 1'b0;
    m_own = o; m_lock = l;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (key_tx) hi++;
    end
    chk(own_bank == o, "R2 own load", own_bank, o);
    chk(lock_bank == l, "R2 lock load", lock_bank, l);
    chk(hi == 0, "R2 quiet before init", hi, 0);
  endtask

  // Plays one full round plus its scramble exchange.
  task automatic t_round(input int start, input logic md, input logic [63:0] own_n,
                         input logic [63:0] lock_n, input bit poke, input int exp_round);
    int hi = 0, exp_hi = 0, bad = 0, cyc = 0;
    logic [63:0] ob, lb;
    logic [3:0] n3;
    int exp_start;
    logic exp_mode;
    for (int i = start; i < 16; i++) if (md && m_own[i*4]) exp_hi += 2;
    chk(int'(cur_index) == start, "R6 R10 round start index", cur_index, start);
    ob = own_bank; lb = lock_bank;
    while (!host_rst && cyc < 400) begin
      if (key_tx && !(md && m_own[cur_index*4])) bad++;
      if (key_tx) hi++;
      if (poke && cyc == 10) begin
        own_wdata = 64'hDEAD_BEEF_0BAD_F00D; lock_wdata = 64'hDEAD_BEEF_0BAD_F00D; bank_wr = 1'b1;
      end
      if (poke && cyc == 11) bank_wr = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(hi == exp_hi, "R3 key_tx high cycles", hi, exp_hi);
    chk(bad == 0, "R3 key_tx bit per index", bad, 0);
    chk(halted == 0, "R4 matching replies accepted", halted, 0);
    chk(cur_index == 4'd15, "R6 round ends at 15", cur_index, 15);
    if (poke) chk(own_bank == ob && lock_bank == lb, "R12 mid-round write ignored", lock_bank, lb);
    @(negedge clk);
    chk(host_rst == 0 && scr_req == 1, "R7 single pulse then request", {host_rst, scr_req}, 1);
    for (int p = 0; p < 3; p++) begin
      cyc = 0;
      while (!scr_req && cyc < 20) begin @(negedge clk); cyc++; end
      chk(scr_req == 1, "R7 scramble request", p, p);
      own_wdata  = (p == 2) ? own_n : ~own_n;
      lock_wdata = (p == 2) ? lock_n : (lock_n ^ 64'h5555_5555_5555_5555);
      bank_wr = 1'b1;
      @(negedge clk);
      bank_wr = 1'b0;
    end
    chk(scr_req == 0, "R7 no fourth request", scr_req, 0);
    @(negedge clk);
    n3 = lock_n[15:12];
    exp_start = n3[0] ? 1 : int'(n3);
    exp_mode  = lock_n[28];
    m_own = own_n; m_lock = swp(lock_n);
    chk(lock_bank == swp(lock_n), "R8 nibble exchange", lock_bank, swp(lock_n));
    chk(own_bank == own_n, "R8 own bank kept", own_bank, own_n);
    chk(mode_bit == exp_mode, "R9 mode from nibble 3", mode_bit, exp_mode);
    chk(int'(cur_index) == exp_start, "R10 next start index", cur_index, exp_start);
    chk(int'(round_cnt) == exp_round, "R11 round count", round_cnt, exp_round);
  endtask

  task automatic t_halt(input int bad_at);
    int cyc = 0;
    logic [7:0] rc;
    rc = round_cnt;
    bad_idx = bad_at; corrupt = 1'b1;
    while (!halted && cyc < 400) begin @(negedge clk); cyc++; end
    chk(halted == 1, "R4 mismatch halts", halted, 1);
    chk(int'(cur_index) == bad_at, "R5 halt index", cur_index, bad_at);
    corrupt = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || key_tx || scr_req) cyc = -1;
    end
    chk(cyc != -1, "R5 halt held and quiet", cyc, 0);
    chk(round_cnt == rc, "R5 round frozen", round_cnt, rc);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_idle_load(64'h9C3A_5E71_D2B8_46F1, 64'h5B27_E1C9_843F_A06D);
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    t_round(1, 1'b1, 64'h6B3F_92D4_1E87_C5A1, 64'h3D91_C4A8_8E2B_5F07, 1'b0, 1);
    t_round(1, 1'b0, 64'hF0E1_D2C3_B4A5_9687, 64'hA7E2_0C5D_3B94_6E1F, 1'b1, 2);
    t_round(6, 1'b1, 64'h2468_ACE1_3579_BDF0, 64'h1F2E_3D4C_5B6A_7988, 1'b0, 3);
    t_halt(9);
    do_reset();
    t_reset_state();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule